// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This block is the arithmetic and logic engine of an 8-bit processor core. Each cycle it takes an operation code, two byte operands, a carry (or borrow) input and a half-carry input. It returns a result, a five-bit condition flag vector and a five-bit update mask. The mask marks the flags that the selected operation changes. The register file that holds the flags merges the two: where a mask bit is set it loads the new flag, and elsewhere it keeps its old value.

The supported operations are:

- add and add with carry;
- subtract, subtract with borrow and compare;
- negate, increment and decrement;
- AND, OR, XOR, bit test, load pass-through, test, clear and complement;
- left and right shifts, arithmetic and logical, and rotates through carry;
- decimal adjust after BCD addition;
- an unsigned 8x8 multiply with a 16-bit product.

Each operation has its own fixed set of flags that it changes, and its own rule for each of them. Decoding of instructions, register storage and memory access are handled elsewhere. The operation codes are the `alu_op_e` enumeration in `alu8_pkg`. The outputs are registered, so the results for the inputs present at a rising clock edge appear after that edge.

Top module: `alu8_cc`

## Requirements
- R1: All outputs are registered. The values for the inputs sampled at a rising edge appear after that edge and stay stable until the next edge. While rst_n is low, result, flags and mask are all zero.
- R2: The flag vector and the mask use bit 4 for H, bit 3 for N, bit 2 for Z, bit 1 for V and bit 0 for C. Any flag bit whose mask bit is clear reads 0. When Z is updated, it is 1 exactly when the 16-bit result is zero. For every operation except multiply, N equals bit 7 of the result.
- R3: Add returns a+b and add-with-carry returns a+b+carry_i. Both update all five flags: H is the carry out of bit 3, C is the carry out of bit 7 and V is signed overflow.
- R4: Subtract returns a-b and subtract-with-borrow returns a-b-carry_i. Compare returns a-b as well. All three update N, Z, V and C, with C set on a borrow and V set on signed overflow. H is not updated.
- R5: Negate returns 0-a and updates N, Z, V and C. C is 1 unless a is 0x00. V is 1 only for a = 0x80.
- R6: AND, OR, XOR and bit test (a AND b) return the bitwise result. Load returns b and test returns a. All six update N and Z, clear V and leave C and H alone.
- R7: Clear returns 0 with N=0, Z=1, V=0, C=0. Complement returns ~a with V=0 and C=1. Both update N, Z, V and C.
- R8: Increment returns a+1 and decrement returns a-1. Both update N, Z and V, where V is set by a = 0x7F for increment and by a = 0x80 for decrement. C is left alone.
- R9: Shift left returns a<<1 and rotate left returns a<<1 with carry_i entering bit 0. Both set C to input bit 7 and V to input bit 7 XOR input bit 6, and update N, Z, V and C.
- R10: Logical shift right fills bit 7 with 0, arithmetic shift right keeps bit 7, and rotate right brings carry_i into bit 7. All three put input bit 0 into C and update N, Z and C. V is left alone.
- R11: Decimal adjust adds 0x06 when half_i is 1 or the low nibble exceeds 9. It adds 0x60 when carry_i is 1 or a exceeds 0x99, and in that case C becomes 1; otherwise C equals carry_i. It updates N, Z, V and C, and V is cleared.
- R12: Multiply returns the 16-bit unsigned product a*b. It updates only Z (set when the product is zero) and C (bit 7 of the product).
- R13: Operation codes 23 to 31 are unassigned. They give a zero result, zero flags and a zero mask.
- R14: For every operation other than multiply, result bits 15:8 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code (`alu_op_e`) |
| a_i | input | 8 | First operand, also the sole operand of unary operations |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry or borrow input |
| half_i | input | 1 | Half-carry input, used by decimal adjust |
| result_o | output | 16 | Result; the upper byte is used only by multiply |
| flags_o | output | 5 | New flags {H,N,Z,V,C}, zero where not updated |
| upd_o | output | 5 | Per-flag update mask {H,N,Z,V,C} |

## Verification
Two things can land on the same flag in one cycle: the incoming carry being consumed, and a new carry being generated. This happens in add-with-carry, subtract-with-borrow, the rotates and decimal adjust. In add-with-carry, for example, a=0xFF, b=0x00 with carry_i set yields a carry out and a half-carry caused only by the incoming carry, and a=0x7F with carry_i set yields a signed overflow. The bench sweeps every operation code against all 256 values of a. It pairs them with a set of b values that includes 0x00, 0x7F, 0x80 and 0xFF, and with both states of carry_i. It judges each vector against an arithmetic model written in integers straight from the requirement text.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W    = 8;
    localparam int PROD_W   = 2 * ALU_W;
    localparam int FLAG_W   = 5;
    localparam int OP_W     = 5;
    localparam int OP_COUNT = 23;

    localparam int FL_H = 4;
    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_V = 1;
    localparam int FL_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_CMP = 5'd4,
        OP_NEG = 5'd5,
        OP_AND = 5'd6,
        OP_OR  = 5'd7,
        OP_XOR = 5'd8,
        OP_BIT = 5'd9,
        OP_LD  = 5'd10,
        OP_TST = 5'd11,
        OP_CLR = 5'd12,
        OP_COM = 5'd13,
        OP_INC = 5'd14,
        OP_DEC = 5'd15,
        OP_ASL = 5'd16,
        OP_ASR = 5'd17,
        OP_LSR = 5'd18,
        OP_ROL = 5'd19,
        OP_ROR = 5'd20,
        OP_DAA = 5'd21,
        OP_MUL = 5'd22
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_FIRST_FREE = OP_W'(OP_COUNT);

    typedef struct packed {
        logic [PROD_W-1:0] res;
        logic [FLAG_W-1:0] flg;
        logic [FLAG_W-1:0] upd;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int NIB = 4;

    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [W:0]     full;
    logic [NIB:0]   low_nib;

    always_comb begin
        b_eff   = sub ? ~b : b;
        c_eff   = sub ? ~cin : cin;
        full    = {1'b0, a} + {1'b0, b_eff} + (W+1)'(c_eff);
        low_nib = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + (NIB+1)'(c_eff);
        sum     = full[W-1:0];
        c_out   = sub ? ~full[W] : full[W];
        h_out   = low_nib[NIB];
        v_out   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_BIT: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_LD:          res = b;
            OP_TST:         res = a;
            OP_COM:         res = ~a;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         v_out
);
    always_comb begin
        res   = '0;
        c_out = 1'b0;
        v_out = 1'b0;
        unique case (op)
            OP_ASL: begin
                res   = {a[W-2:0], 1'b0};
                c_out = a[W-1];
                v_out = a[W-1] ^ a[W-2];
            end
            OP_ROL: begin
                res   = {a[W-2:0], cin};
                c_out = a[W-1];
                v_out = a[W-1] ^ a[W-2];
            end
            OP_ASR: begin
                res   = {a[W-1], a[W-1:1]};
                c_out = a[0];
            end
            OP_LSR: begin
                res   = {1'b0, a[W-1:1]};
                c_out = a[0];
            end
            OP_ROR: begin
                res   = {cin, a[W-1:1]};
                c_out = a[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj (
    input  logic [7:0] a,
    input  logic       cin,
    input  logic       hin,
    output logic [7:0] res,
    output logic       c_out
);
    localparam logic [3:0] DIGIT_MAX = 4'd9;
    localparam logic [3:0] FIX       = 4'd6;

    logic [3:0] lo;
    logic [3:0] hi;
    logic       fix_lo;
    logic       fix_hi;

    always_comb begin
        lo     = a[3:0];
        hi     = a[7:4];
        fix_lo = hin || (lo > DIGIT_MAX);
        fix_hi = cin || (hi > DIGIT_MAX) || ((hi > (DIGIT_MAX - 4'd1)) && (lo > DIGIT_MAX));
        res    = a + {(fix_hi ? FIX : 4'd0), (fix_lo ? FIX : 4'd0)};
        c_out  = cin | fix_hi;
    end
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [ALU_W-1:0]  a_i,
    input  logic [ALU_W-1:0]  b_i,
    input  logic              carry_i,
    input  logic              half_i,
    output logic [PROD_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] upd_o
);
    localparam logic [FLAG_W-1:0] M_ALL   = 5'b11111;
    localparam logic [FLAG_W-1:0] M_NZVC  = 5'b01111;
    localparam logic [FLAG_W-1:0] M_NZV   = 5'b01110;
    localparam logic [FLAG_W-1:0] M_NZC   = 5'b01101;
    localparam logic [FLAG_W-1:0] M_ZC    = 5'b00101;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // shared adder operand selection
    logic [ALU_W-1:0] add_a;
    logic [ALU_W-1:0] add_b;
    logic             add_ci;
    logic             add_sub;
    logic [ALU_W-1:0] add_sum;
    logic             add_c;
    logic             add_h;
    logic             add_v;

    always_comb begin
        add_a   = a_i;
        add_b   = b_i;
        add_ci  = 1'b0;
        add_sub = 1'b0;
        unique case (op)
            OP_ADC: add_ci = carry_i;
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBC: begin
                add_sub = 1'b1;
                add_ci  = carry_i;
            end
            OP_NEG: begin
                add_a   = '0;
                add_b   = a_i;
                add_sub = 1'b1;
            end
            OP_INC: add_b = ALU_W'(1);
            OP_DEC: begin
                add_b   = ALU_W'(1);
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.W(ALU_W)) u_addsub (
        .a     (add_a),
        .b     (add_b),
        .cin   (add_ci),
        .sub   (add_sub),
        .sum   (add_sum),
        .c_out (add_c),
        .h_out (add_h),
        .v_out (add_v)
    );

    logic [ALU_W-1:0] log_res;

    alu8_logic #(.W(ALU_W)) u_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .res (log_res)
    );

    logic [ALU_W-1:0] sh_res;
    logic             sh_c;
    logic             sh_v;

    alu8_shift #(.W(ALU_W)) u_shift (
        .op    (op),
        .a     (a_i),
        .cin   (carry_i),
        .res   (sh_res),
        .c_out (sh_c),
        .v_out (sh_v)
    );

    logic [ALU_W-1:0] daa_res;
    logic             daa_c;

    alu8_decadj u_decadj (
        .a     (a_i),
        .cin   (carry_i),
        .hin   (half_i),
        .res   (daa_res),
        .c_out (daa_c)
    );

    logic [PROD_W-1:0] product;
    assign product = PROD_W'(a_i) * PROD_W'(b_i);

    alu_out_t nxt_d;
    alu_out_t cur_q;

    always_comb begin
        logic [ALU_W-1:0]  r8;
        logic [FLAG_W-1:0] mask;
        logic [FLAG_W-1:0] f;
        logic              is_mul;

        r8     = '0;
        mask   = '0;
        f      = '0;
        is_mul = 1'b0;

        unique case (op)
            OP_ADD, OP_ADC: begin
                r8      = add_sum;
                f[FL_H] = add_h;
                f[FL_V] = add_v;
                f[FL_C] = add_c;
                mask    = M_ALL;
            end
            OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                r8      = add_sum;
                f[FL_V] = add_v;
                f[FL_C] = add_c;
                mask    = M_NZVC;
            end
            OP_INC, OP_DEC: begin
                r8      = add_sum;
                f[FL_V] = add_v;
                mask    = M_NZV;
            end
            OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LD, OP_TST: begin
                r8   = log_res;
                mask = M_NZV;
            end
            OP_CLR: begin
                r8   = '0;
                mask = M_NZVC;
            end
            OP_COM: begin
                r8      = log_res;
                f[FL_C] = 1'b1;
                mask    = M_NZVC;
            end
            OP_ASL, OP_ROL: begin
                r8      = sh_res;
                f[FL_V] = sh_v;
                f[FL_C] = sh_c;
                mask    = M_NZVC;
            end
            OP_ASR, OP_LSR, OP_ROR: begin
                r8      = sh_res;
                f[FL_C] = sh_c;
                mask    = M_NZC;
            end
            OP_DAA: begin
                r8      = daa_res;
                f[FL_C] = daa_c;
                mask    = M_NZVC;
            end
            OP_MUL: begin
                is_mul  = 1'b1;
                f[FL_C] = product[ALU_W-1];
                mask    = M_ZC;
            end
            default: ;
        endcase

        if (is_mul) begin
            nxt_d.res = product;
            f[FL_Z]   = (product == '0);
        end else begin
            nxt_d.res = PROD_W'(r8);
            f[FL_N]   = r8[ALU_W-1];
            f[FL_Z]   = (r8 == '0);
        end
        nxt_d.flg = f & mask;
        nxt_d.upd = mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign result_o = cur_q.res;
    assign flags_o  = cur_q.flg;
    assign upd_o    = cur_q.upd;

endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [ALU_W-1:0]  a_i,
    input logic [ALU_W-1:0]  b_i,
    input logic [PROD_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] upd_o
);
    assert_masked_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~upd_o) == '0);

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o[FL_Z] |-> (flags_o[FL_Z] == (result_o == '0)));

    assert_half_only_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o[FL_H] |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_ADC));

    assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLR) |=> (flags_o == 5'b00100 && upd_o == 5'b01111));

    assert_mul_product_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MUL) |=>
            (result_o == ({8'h00, $past(a_i)} * {8'h00, $past(b_i)})));

    assert_free_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= OP_FIRST_FREE) |=> (upd_o == '0 && result_o == '0));

    assert_high_byte_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_MUL) |=> (result_o[PROD_W-1:ALU_W] == '0));
endmodule

bind alu8_cc alu8_cc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .upd_o    (upd_o)
);

// File: tb/alu8_cc_tb.sv
module alu8_cc_tb;
    import alu8_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic        carry_i = 1'b0;
    logic        half_i = 1'b0;
    logic [15:0] result_o;
    logic [4:0]  flags_o;
    logic [4:0]  upd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [25:0] prev_exp = '0;

    always #10 clk = ~clk;

    alu8_cc u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .carry_i  (carry_i),
        .half_i   (half_i),
        .result_o (result_o),
        .flags_o  (flags_o),
        .upd_o    (upd_o)
    );

    function automatic string req_tag(input logic [4:0] code);
        case (code)
            OP_ADD, OP_ADC:                      return "R3";
            OP_SUB, OP_SBC, OP_CMP:              return "R4";
            OP_NEG:                              return "R5";
            OP_AND, OP_OR, OP_XOR, OP_BIT,
            OP_LD, OP_TST:                       return "R6";
            OP_CLR, OP_COM:                      return "R7";
            OP_INC, OP_DEC:                      return "R8";
            OP_ASL, OP_ROL:                      return "R9";
            OP_ASR, OP_LSR, OP_ROR:              return "R10";
            OP_DAA:                              return "R11";
            OP_MUL:                              return "R12";
            default:                             return "R13";
        endcase
    endfunction

    // {result[15:0], flags[4:0], mask[4:0]} from the requirement text
    function automatic logic [25:0] model(input logic [4:0] code, input logic [7:0] a,
                                          input logic [7:0] b, input logic ci, input logic hi);
        int ia, ib, sa, sb, s, ss, r, cc, corr, p;
        logic fh, fn, fz, fv, fc;
        logic [4:0] m;
        logic [15:0] res;
        ia = int'(a); ib = int'(b);
        sa = a[7] ? ia - 256 : ia;
        sb = b[7] ? ib - 256 : ib;
        fh = 0; fn = 0; fz = 0; fv = 0; fc = 0; m = 5'b00000; r = 0; p = 0;
        case (code)
            OP_ADD, OP_ADC: begin
                cc = (code == OP_ADC && ci) ? 1 : 0;
                s = ia + ib + cc; r = s % 256; fc = (s > 255);
                fh = ((ia % 16) + (ib % 16) + cc) > 15;
                ss = sa + sb + cc; fv = (ss > 127) || (ss < -128);
                m = 5'b11111;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                cc = (code == OP_SBC && ci) ? 1 : 0;
                s = ia - ib - cc; r = (s + 512) % 256; fc = (s < 0);
                ss = sa - sb - cc; fv = (ss > 127) || (ss < -128);
                m = 5'b01111;
            end
            OP_NEG: begin
                r = (256 - ia) % 256; fc = (ia != 0); fv = (-sa > 127);
                m = 5'b01111;
            end
            OP_INC: begin r = (ia + 1) % 256; fv = (sa + 1 > 127); m = 5'b01110; end
            OP_DEC: begin r = (ia + 255) % 256; fv = (sa - 1 < -128); m = 5'b01110; end
            OP_AND: begin r = ia & ib; m = 5'b01110; end
            OP_OR:  begin r = ia | ib; m = 5'b01110; end
            OP_XOR: begin r = ia ^ ib; m = 5'b01110; end
            OP_BIT: begin r = ia & ib; m = 5'b01110; end
            OP_LD:  begin r = ib; m = 5'b01110; end
            OP_TST: begin r = ia; m = 5'b01110; end
            OP_CLR: begin r = 0; m = 5'b01111; end
            OP_COM: begin r = 255 - ia; fc = 1; m = 5'b01111; end
            OP_ASL, OP_ROL: begin
                cc = (code == OP_ROL && ci) ? 1 : 0;
                r = (ia * 2 + cc) % 256; fc = a[7]; fv = a[7] ^ a[6];
                m = 5'b01111;
            end
            OP_ASR: begin r = ia / 2 + (a[7] ? 128 : 0); fc = a[0]; m = 5'b01101; end
            OP_LSR: begin r = ia / 2; fc = a[0]; m = 5'b01101; end
            OP_ROR: begin r = ia / 2 + (ci ? 128 : 0); fc = a[0]; m = 5'b01101; end
            OP_DAA: begin
                corr = 0; fc = ci;
                if (hi || (ia % 16) > 9) corr = corr + 6;
                if (ci || ia > 153) begin corr = corr + 96; fc = 1; end
                r = (ia + corr) % 256;
                m = 5'b01111;
            end
            OP_MUL: begin
                p = ia * ib; fc = ((p / 128) % 2) == 1; fz = (p == 0);
                m = 5'b00101;
            end
            default: m = 5'b00000;
        endcase
        if (code == OP_MUL) begin
            res = 16'(p);
        end else begin
            res = 16'(r);
            fn = (r >= 128);
            fz = (r == 0);
        end
        return {res, ({fh, fn, fz, fv, fc} & m), m};
    endfunction

    task automatic judge(input string tag, input string what, input logic [25:0] expv);
        n_chk++;
        if ({result_o, flags_o, upd_o} !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual res=%h flg=%b upd=%b expected res=%h flg=%b upd=%b",
                     tag, what, result_o, flags_o, upd_o, expv[25:10], expv[9:5], expv[4:0]);
        end
    endtask

    // drive at negedge, confirm hold (R1), capture at posedge, check at next negedge
    task automatic apply(input logic [4:0] code, input logic [7:0] a, input logic [7:0] b,
                         input logic ci, input logic hi, input bit hold_check);
        logic [25:0] e;
        op_i = code; a_i = a; b_i = b; carry_i = ci; half_i = hi;
        e = model(code, a, b, ci, hi);
        if (hold_check) begin
            #2;
            judge("R1", "output changed before edge", prev_exp);
        end
        @(posedge clk);
        @(negedge clk);
        judge(req_tag(code), $sformatf("op=%0d a=%h b=%h c=%b h=%b", code, a, b, ci, hi), e);
        // R2 and R14 are covered by the full-vector comparison above
        prev_exp = e;
    endtask

    initial begin
        #(190000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] bset [8];
        bset = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'h9A, 8'hF0, 8'hFF};

        // R1: reset holds outputs at zero regardless of inputs
        op_i = OP_ADD; a_i = 8'hFF; b_i = 8'h01; carry_i = 1'b1; half_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        judge("R1", "reset state", 26'd0);
        rst_n = 1'b1;

        // R3 corner: carry-in alone produces carry-out and half-carry
        apply(OP_ADC, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
        // R3 corner: carry-in alone produces signed overflow
        apply(OP_ADC, 8'h7F, 8'h00, 1'b1, 1'b0, 1'b1);
        // R12 corner: largest product
        apply(OP_MUL, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1);

        // sweep all codes, including unassigned ones for R13
        for (int k = 0; k < 32; k++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(5'(k), 8'(a), bset[j], c[0], j[0] ^ a[1], 1'b1);
                    end
                end
            end
        end

        // R12: wider multiply sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b++) begin
                apply(OP_MUL, 8'(a), 8'(b), 1'b0, 1'b0, 1'b1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule